// File: doc/BRIEF.md
# DC Offset Removal Filter

This block sits behind a decimation filter and removes any constant offset from the decimated stream. It handles a stereo stream: each incoming sample carries a tag saying whether it belongs to the left or the right channel. Each channel keeps its own running estimate of the DC level, a leaky integrator with extra fractional bits. Every sample leaves with that channel's current estimate subtracted, and the result is clamped to the sample width.

A hold input stops the estimates from moving. The values already reached are still subtracted from every sample. A system offset calibration therefore takes two steps: run with hold low until the estimates have settled, then raise hold and keep the settled correction for as long as needed. The hold input only matters on cycles that carry a sample.

Top module: `dc_trim`

## Requirements
- R1: Each sample accepted while `valid_i` is high appears exactly one clock later with `valid_o` high. `chan_o` repeats that sample's `chan_i`, where 0 is the left channel and 1 is the right channel.
- R2: The output value is `sample_i - floor(est/2^FRAC_W)`, using that channel's estimate as it stood before the sample arrived. The estimate `est` is a signed fixed-point value with FRAC_W fractional bits.
- R3: On a sample with `hold_i` low, the channel's estimate becomes `est + floor((sample_i*2^FRAC_W - est) / 2^SHIFT_K)`.
- R4: On a sample with `hold_i` high, the channel's estimate keeps its value, and that held value is still subtracted as in R2.
- R5: A sample on one channel never changes the other channel's estimate.
- R6: When the difference falls outside the signed DATA_W range, the output is clamped to the largest or smallest representable value. It does not wrap.
- R7: Reset clears both estimates to zero and holds `valid_o` low.
- R8: In a cycle with `valid_i` low, `valid_o` goes low on the next clock. Neither estimate changes, whatever `hold_i`, `chan_i` or `sample_i` are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| chan_i | input | 1 | Channel tag: 0 left, 1 right |
| hold_i | input | 1 | Freeze the offset estimates |
| sample_i | input | DATA_W | Signed input sample |
| valid_o | output | 1 | Output sample strobe |
| chan_o | output | 1 | Channel tag of the output sample |
| sample_o | output | DATA_W | Signed, offset-corrected sample |

## Verification
The bench builds the block with DATA_W=16, FRAC_W=4 and SHIFT_K=3. With a shift of only 3, an estimate settles within a few dozen samples, so settling, holding after settling, and independent left and right offsets all fit in a short run. The 16-bit width lets a long full-scale run push an estimate close to either rail. An opposite full-scale sample then drives the output into both saturation limits.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/dc_trim_track.sv
module dc_trim_track #(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 8,
  parameter int SHIFT_K = 10,
  localparam int ACC_W  = DATA_W + FRAC_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic [DATA_W-1:0]        sample_i,
  output logic signed [ACC_W-1:0]  est_o
);
  logic signed [ACC_W-1:0] est_q;
  logic signed [ACC_W:0]   tgt, est_ext, diff, step, nxt;

  always_comb begin
    tgt     = {sample_i[DATA_W-1], sample_i, {FRAC_W{1'b0}}};
    est_ext = {est_q[ACC_W-1], est_q};
    diff    = tgt - est_ext;
    step    = diff >>> SHIFT_K;
    nxt     = est_ext + step;  // lies between est and target, fits ACC_W
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    est_q <= '0;
    else if (upd_i) est_q <= nxt[ACC_W-1:0];
  end

  assign est_o = est_q;

  AST_EST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> est_q == $past(est_q));  // R4
  AST_EST_RISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && tgt > est_ext) |=> est_q >= $past(est_q));  // R3
  AST_EST_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && tgt < est_ext) |=> est_q <= $past(est_q));  // R3
endmodule

// File: rtl/dc_trim_sub.sv
module dc_trim_sub #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 8,
  localparam int ACC_W = DATA_W + FRAC_W
) (
  input  logic [DATA_W-1:0]       sample_i,
  input  logic signed [ACC_W-1:0] est_i,
  output logic [DATA_W-1:0]       sample_o
);
  logic signed [DATA_W:0] diff;
  logic [DATA_W-1:0] max_v, min_v;

  always_comb begin
    max_v = {1'b0, {(DATA_W-1){1'b1}}};
    min_v = {1'b1, {(DATA_W-1){1'b0}}};
    // integer part of est = floor(est / 2^FRAC_W)
    diff = {sample_i[DATA_W-1], sample_i} - {est_i[ACC_W-1], est_i[ACC_W-1:FRAC_W]};
    if (diff[DATA_W] != diff[DATA_W-1]) sample_o = diff[DATA_W] ? min_v : max_v;
    else                                sample_o = diff[DATA_W-1:0];
  end

  always_comb begin
    AST_SAT_SIGN: assert (diff[DATA_W] == sample_o[DATA_W-1]);  // R6
  end
endmodule

// File: rtl/dc_trim.sv
module dc_trim
  import dc_trim_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 8,
  parameter int SHIFT_K = 10,
  localparam int ACC_W  = DATA_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              chan_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              valid_o,
  output logic              chan_o,
  output logic [DATA_W-1:0] sample_o
);
  logic signed [ACC_W-1:0] est [NUM_CH];
  logic signed [ACC_W-1:0] est_sel;
  logic [DATA_W-1:0]       corr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic upd;
    assign upd = valid_i && !hold_i && (chan_i == g[0]);
    dc_trim_track #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT_K(SHIFT_K)) u_track (
      .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .sample_i(sample_i), .est_o(est[g])
    );
  end

  assign est_sel = (chan_e'(chan_i) == CH_RIGHT) ? est[1] : est[0];

  dc_trim_sub #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_sub (
    .sample_i(sample_i), .est_i(est_sel), .sample_o(corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      chan_o   <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        chan_o   <= chan_i;
        sample_o <= corr;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o && chan_o == $past(chan_i));  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R8
  AST_OTHER_CH_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !chan_i) |=> est[1] == $past(est[1]));  // R5
endmodule

// File: tb/dc_trim_test.sv
module dc_trim_test;
  localparam int DW = 16, FW = 4, SK = 3;
  localparam int MAXV = 32767, MINV = -32768;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0, chan_i = 0, hold_i = 0;
  logic [DW-1:0] sample_i = '0;
  logic valid_o, chan_o;
  logic [DW-1:0] sample_o;

  int total = 0, bad = 0;
  bit done = 0;
  longint est [2];

  always #2 clk = ~clk;

  dc_trim #(.DATA_W(DW), .FRAC_W(FW), .SHIFT_K(SK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .chan_i(chan_i), .hold_i(hold_i),
    .sample_i(sample_i), .valid_o(valid_o), .chan_o(chan_o), .sample_o(sample_o)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  // drive one cycle at negedge, check outputs at the following negedge
  task automatic step(input bit v, input bit ch, input int x, input bit h, input string rq);
    longint y, ey;
    valid_i = v; chan_i = ch; hold_i = h; sample_i = x[DW-1:0];
    ey = 0;
    if (v) begin
      y = longint'(x) - (est[ch] >>> FW);
      ey = (y > MAXV) ? MAXV : (y < MINV) ? MINV : y;
      if (!h) est[ch] = est[ch] + ((longint'(x) * (1 << FW) - est[ch]) >>> SK);
    end
    @(posedge clk); @(negedge clk);
    chk(valid_o == v, {rq, " R1 valid"}, valid_o, v);
    if (v) begin
      chk(chan_o == ch, {rq, " R1 chan"}, chan_o, ch);
      chk($signed(sample_o) == ey, rq, $signed(sample_o), ey);
    end
  endtask

  initial begin
    est[0] = 0; est[1] = 0;
    repeat (3) @(negedge clk);
    chk(valid_o == 0, "R7 valid in reset", valid_o, 0);
    rst_n = 1;
    // first samples: estimates zero, output equals input
    step(1, 0, 1234, 0, "R2 first left");
    step(1, 1, -77, 0, "R2 first right");
    // settle with distinct offsets per channel
    for (int i = 0; i < 150; i++) begin
      step(1, 0, 1000 + (i % 7) - 3, 0, "R3 settle left");
      step(1, 1, -500 + (i % 5) - 2, 0, "R5 settle right");
    end
    // idle cycles with noise on other inputs
    for (int i = 0; i < 10; i++) step(0, i[0], 20000 * (i % 3) - 9000, i[1], "R8 idle");
    step(1, 0, 1000, 1, "R8 est unchanged after idle");
    // freeze and move the input level
    for (int i = 0; i < 40; i++) begin
      step(1, 0, 3000 + i, 1, "R4 held left");
      step(1, 1, -2000 - i, 1, "R4 held right");
    end
    // only left runs, right must keep its value
    for (int i = 0; i < 40; i++) step(1, 0, 5000, 0, "R5 left only");
    step(1, 1, -500, 1, "R5 right untouched");
    // push left estimate to top rail, then negative full scale
    for (int i = 0; i < 200; i++) step(1, 0, MAXV, 0, "R3 ramp up");
    step(1, 0, MINV, 1, "R6 low clamp");
    for (int i = 0; i < 200; i++) step(1, 1, MINV, 0, "R3 ramp down");
    step(1, 1, MAXV, 1, "R6 high clamp");
    // reset mid run clears estimates
    rst_n = 0;
    @(negedge clk);
    chk(valid_o == 0, "R7 valid low in reset", valid_o, 0);
    est[0] = 0; est[1] = 0;
    rst_n = 1;
    step(1, 0, 4321, 0, "R7 left cleared");
    step(1, 1, -4321, 0, "R7 right cleared");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule